// File: doc/BRIEF.md
# Two-Channel Quadrature Pulse Counter

This block counts edges on two pulse inputs into one shared 16-bit signed counter. Each channel pairs a pulse input with a control input. A pulse input can pass through a glitch filter that drops pulses shorter than a programmed number of clock cycles. Each edge direction on each channel selects its own step: up, down or none. The level of the channel's control input can keep that step, reverse it or block it. This lets the unit count a plain pulse train, a pulse train with a direction pin, or a quadrature encoder.

Five comparators watch the counter: zero, a high limit, a low limit and two free thresholds. Each one has its own enable. A match on an enabled comparator, in the cycle the counter takes a new value, sets a sticky event flag. The same match latches which comparators fired, together with a two-bit code that gives the sign and direction of the count. A counter that reaches an enabled limit falls back to zero on the next clock. Separate inputs clear the counter and freeze it.

Top module: `pcu_unit`

## Requirements
- R1: After reset, the count, event flag, interrupt, status and mode outputs are all zero.
- R2: For each channel there is a rising-edge action code and a falling-edge action code. Code 1 adds one to the count, code 2 subtracts one, and codes 0 and 3 leave the count unchanged.
- R3: Each channel's control input selects its high-level mode (while high) or its low-level mode (while low). Mode 0 or 3 keeps the edge action, mode 1 reverses it, and mode 2 blocks it. Channel c's codes sit at bits [2c+1:2c] of each code port.
- R4: When both channels produce a step in the same clock, the count changes by the sum of the two steps.
- R5: With the filter enabled and a threshold of T, a pulse lasting fewer than T clock cycles is dropped, and a pulse lasting at least T cycles is counted. With the filter disabled, every pulse is counted.
- R6: While the hold input is high, edges do not change the count.
- R7: The clear input sets the count to zero on the next clock. Clear takes priority over hold.
- R8: When the count equals an enabled high or low limit, it returns to zero on the next clock.
- R9: In a cycle where the count has just changed and an enabled comparator matches, the event flag is set. The flag stays set until the event-clear input is pulsed, and a new match wins over a clear in the same cycle.
- R10: The interrupt output is the event flag gated by the interrupt-enable input.
- R11: On each event, the status output latches the comparators that matched. Bit 0 is zero, bit 1 is high limit, bit 2 is low limit, bit 3 is threshold 0 and bit 4 is threshold 1. The same bit positions apply to the compare-enable input.
- R12: On each event, the mode output latches one of four codes. Code 0 means the count reached zero from a positive value, 1 means it reached zero from a negative value, 2 means the count is negative, and 3 means the count is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 2 | Pulse input, one bit per channel |
| ctrl_i | input | 2 | Control level, one bit per channel |
| flt_en_i | input | 1 | Glitch filter enable |
| flt_thr_i | input | 10 | Minimum accepted pulse width, in cycles |
| rise_act_i | input | 4 | Rising-edge action code, per channel |
| fall_act_i | input | 4 | Falling-edge action code, per channel |
| hi_mode_i | input | 4 | Control mode while control is high, per channel |
| lo_mode_i | input | 4 | Control mode while control is low, per channel |
| cmp_en_i | input | 5 | Compare enables (bit order as status_o) |
| thr0_i | input | 16 | Threshold 0 |
| thr1_i | input | 16 | Threshold 1 |
| hlim_i | input | 16 | High limit |
| llim_i | input | 16 | Low limit |
| cnt_clr_i | input | 1 | Clear counter |
| cnt_hold_i | input | 1 | Freeze counter |
| evt_clr_i | input | 1 | Write-one-to-clear pulse for the event flag |
| evt_ie_i | input | 1 | Interrupt enable |
| count_o | output | 16 | Current count, two's complement |
| evt_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Gated interrupt |
| status_o | output | 5 | Latched comparator hits |
| zmode_o | output | 2 | Latched sign/zero-crossing code |

## Verification
The two channels can each produce a step in the same clock edge. The bench provokes this by driving both pulse inputs with the same timing, so the filtered edges of the two channels reach the counter together. Table rows with equal steps, opposite steps, and a step reversed by one channel's control mode all check that the final count is the sum of both channels' steps. A dropped or overwritten step shows up as a count that is off by the number of pulses.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef logic signed [1:0] step_t;

  localparam int NCMP     = 5;
  localparam int IDX_ZERO = 0;
  localparam int IDX_HIGH = 1;
  localparam int IDX_LOW  = 2;
  localparam int IDX_TH0  = 3;
  localparam int IDX_TH1  = 4;

  // edge action code -> unit step
  function automatic step_t edge_step(input logic [1:0] act);
    case (act)
      2'd1:    edge_step = 2'sb01;
      2'd2:    edge_step = 2'sb11;
      default: edge_step = 2'sb00;
    endcase
  endfunction

  // control mode applied to a step
  function automatic step_t ctl_apply(input logic [1:0] mode, input step_t s);
    case (mode)
      2'd1:    ctl_apply = -s;
      2'd2:    ctl_apply = 2'sb00;
      default: ctl_apply = s;
    endcase
  endfunction
endpackage

// File: rtl/pcu_filter.sv
module pcu_filter #(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [FW-1:0] thr,
  input  logic          pin,
  output logic          rise_o,
  output logic          fall_o
);
  logic          in_q, lvl_q;
  logic [FW-1:0] run_q;
  logic [FW:0]   run_nx;
  logic          differ, take;

  assign run_nx = {1'b0, run_q} + {{FW{1'b0}}, 1'b1};
  assign differ = in_q != lvl_q;
  assign take   = differ && (!en || (run_nx >= {1'b0, thr}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      in_q   <= pin;
      rise_o <= take & in_q;
      fall_o <= take & ~in_q;
      if (take) begin
        lvl_q <= in_q;
        run_q <= '0;
      end else if (differ) begin
        run_q <= run_nx[FW-1:0];
      end else begin
        run_q <= '0;
      end
    end
  end

  // R5
  filt_edge_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> lvl_q);
endmodule

// File: rtl/pcu_chan.sv
module pcu_chan
  import pcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic [1:0] rise_act,
  input  logic [1:0] fall_act,
  input  logic [1:0] hi_mode,
  input  logic [1:0] lo_mode,
  output step_t      step_o
);
  logic  ctl_q;
  step_t raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 1'b0;
    else        ctl_q <= ctl_i;
  end

  always_comb begin
    if (rise_i)      raw = edge_step(rise_act);
    else if (fall_i) raw = edge_step(fall_act);
    else             raw = 2'sb00;
    step_o = ctl_apply(ctl_q ? hi_mode : lo_mode, raw);
  end
endmodule

// File: rtl/pcu_cmp.sv
module pcu_cmp
  import pcu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cnt,
  input  logic [NCMP-1:0] cmp_en,
  input  logic [CW-1:0]   thr0,
  input  logic [CW-1:0]   thr1,
  input  logic [CW-1:0]   hlim,
  input  logic [CW-1:0]   llim,
  input  logic            evt_clr,
  input  logic            evt_ie,
  output logic [NCMP-1:0] hit_o,
  output logic            evt_o,
  output logic            irq_o,
  output logic [NCMP-1:0] status_o,
  output logic [1:0]      zmode_o
);
  logic [CW-1:0]   prev_q;
  logic [NCMP-1:0] match;
  logic            moved;

  function automatic logic [1:0] zcode(input logic signed [CW-1:0] cur,
                                       input logic signed [CW-1:0] prv);
    if (cur == '0) zcode = (prv < 0) ? 2'd1 : 2'd0;
    else           zcode = (cur < 0) ? 2'd2 : 2'd3;
  endfunction

  always_comb begin
    match           = '0;
    match[IDX_ZERO] = cnt == '0;
    match[IDX_HIGH] = cnt == hlim;
    match[IDX_LOW]  = cnt == llim;
    match[IDX_TH0]  = cnt == thr0;
    match[IDX_TH1]  = cnt == thr1;
  end

  assign moved = cnt != prev_q;
  assign hit_o = match & cmp_en & {NCMP{moved}};
  assign irq_o = evt_o & evt_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      evt_o    <= 1'b0;
      status_o <= '0;
      zmode_o  <= 2'd0;
    end else begin
      prev_q <= cnt;
      evt_o  <= (evt_o & ~evt_clr) | (|hit_o);
      if (|hit_o) begin
        status_o <= hit_o;
        zmode_o  <= zcode($signed(cnt), $signed(prev_q));
      end
    end
  end

  // R9
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_o) |=> evt_o);
  // R9
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !evt_clr) |=> evt_o);
  // R9
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !(|hit_o)) |=> !evt_o);
  // R11
  status_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_o) |=> (status_o == $past(hit_o)));
  // R12
  zmode_from_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_o) && cnt == '0 && $signed(prev_q) < 0) |=> (zmode_o == 2'd1));
endmodule

// File: rtl/pcu_unit.sv
module pcu_unit
  import pcu_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16,
  parameter int FLT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     pulse_i,
  input  logic [NCH-1:0]     ctrl_i,
  input  logic               flt_en_i,
  input  logic [FLT_W-1:0]   flt_thr_i,
  input  logic [2*NCH-1:0]   rise_act_i,
  input  logic [2*NCH-1:0]   fall_act_i,
  input  logic [2*NCH-1:0]   hi_mode_i,
  input  logic [2*NCH-1:0]   lo_mode_i,
  input  logic [NCMP-1:0]    cmp_en_i,
  input  logic [CNT_W-1:0]   thr0_i,
  input  logic [CNT_W-1:0]   thr1_i,
  input  logic [CNT_W-1:0]   hlim_i,
  input  logic [CNT_W-1:0]   llim_i,
  input  logic               cnt_clr_i,
  input  logic               cnt_hold_i,
  input  logic               evt_clr_i,
  input  logic               evt_ie_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               evt_o,
  output logic               irq_o,
  output logic [NCMP-1:0]    status_o,
  output logic [1:0]         zmode_o
);
  step_t                    step [NCH];
  logic [NCH-1:0]           rise, fall;
  logic signed [CNT_W-1:0]  delta;
  logic [CNT_W-1:0]         cnt_q;
  logic                     lim_wrap;
  logic [NCMP-1:0]          hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pcu_filter #(.FW(FLT_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .en(flt_en_i), .thr(flt_thr_i),
      .pin(pulse_i[c]), .rise_o(rise[c]), .fall_o(fall[c])
    );
    pcu_chan u_chan (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctrl_i[c]),
      .rise_i(rise[c]), .fall_i(fall[c]),
      .rise_act(rise_act_i[2*c+1:2*c]), .fall_act(fall_act_i[2*c+1:2*c]),
      .hi_mode(hi_mode_i[2*c+1:2*c]), .lo_mode(lo_mode_i[2*c+1:2*c]),
      .step_o(step[c])
    );
  end

  always_comb begin
    delta = '0;
    for (int c = 0; c < NCH; c++) delta = delta + CNT_W'(step[c]);
  end

  assign lim_wrap = (cmp_en_i[IDX_HIGH] && cnt_q == hlim_i) ||
                    (cmp_en_i[IDX_LOW]  && cnt_q == llim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (cnt_clr_i)   cnt_q <= '0;
    else if (lim_wrap)    cnt_q <= '0;
    else if (!cnt_hold_i) cnt_q <= cnt_q + delta;
  end

  assign count_o = cnt_q;

  pcu_cmp #(.CW(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cmp_en(cmp_en_i),
    .thr0(thr0_i), .thr1(thr1_i), .hlim(hlim_i), .llim(llim_i),
    .evt_clr(evt_clr_i), .evt_ie(evt_ie_i), .hit_o(hit),
    .evt_o(evt_o), .irq_o(irq_o), .status_o(status_o), .zmode_o(zmode_o)
  );

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hold_i && !cnt_clr_i && !lim_wrap) |=> $stable(cnt_q));
  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (cnt_q == '0));
  // R8
  limit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wrap && !cnt_clr_i) |=> (cnt_q == '0));
  // R8
  limit_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[IDX_HIGH] || hit[IDX_LOW]) |-> lim_wrap);
endmodule

// File: tb/pcu_unit_tb.sv
module pcu_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pulse_i = '0, ctrl_i = '0;
  logic        flt_en_i = 1'b0;
  logic [9:0]  flt_thr_i = '0;
  logic [3:0]  rise_act_i = '0, fall_act_i = '0, hi_mode_i = '0, lo_mode_i = '0;
  logic [4:0]  cmp_en_i = '0;
  logic [15:0] thr0_i = '0, thr1_i = '0, hlim_i = '0, llim_i = '0;
  logic        cnt_clr_i = 1'b0, cnt_hold_i = 1'b0, evt_clr_i = 1'b0, evt_ie_i = 1'b0;
  logic [15:0] count_o;
  logic        evt_o, irq_o;
  logic [4:0]  status_o;
  logic [1:0]  zmode_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .ctrl_i(ctrl_i),
    .flt_en_i(flt_en_i), .flt_thr_i(flt_thr_i), .rise_act_i(rise_act_i),
    .fall_act_i(fall_act_i), .hi_mode_i(hi_mode_i), .lo_mode_i(lo_mode_i),
    .cmp_en_i(cmp_en_i), .thr0_i(thr0_i), .thr1_i(thr1_i), .hlim_i(hlim_i),
    .llim_i(llim_i), .cnt_clr_i(cnt_clr_i), .cnt_hold_i(cnt_hold_i),
    .evt_clr_i(evt_clr_i), .evt_ie_i(evt_ie_i), .count_o(count_o),
    .evt_o(evt_o), .irq_o(irq_o), .status_o(status_o), .zmode_o(zmode_o)
  );

  typedef struct packed {
    logic [1:0] ra0, fa0, ra1, fa1, hm0, lm0, hm1, lm1;
    logic [1:0] ctl, msk;
    logic signed [7:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'b00, 2'b01,  8'sd3},
    '{2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'b00, 2'b01,  8'sd6},
    '{2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'b00, 2'b01, -8'sd3},
    '{2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'b00, 2'b01, -8'sd3},
    '{2'd1, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'b01, 2'b01,  8'sd0},
    '{2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'b01, 2'b01, -8'sd3},
    '{2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'b00, 2'b01,  8'sd0},
    '{2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'b00, 2'b11,  8'sd6},
    '{2'd1, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'b00, 2'b11,  8'sd0},
    '{2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd3, 2'b00, 2'b10, -8'sd3},
    '{2'd0, 2'd2, 2'd0, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'b01, 2'b01, -8'sd3},
    '{2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'b00, 2'b11,  8'sd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulses(input logic [1:0] m, input int n, input int w);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pulse_i = m;
      repeat (w) @(negedge clk);
      pulse_i = '0;
      repeat (w) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe_clr();
    @(negedge clk) cnt_clr_i = 1'b1;
    @(negedge clk) cnt_clr_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe_evt_clr();
    @(negedge clk) evt_clr_i = 1'b1;
    @(negedge clk) evt_clr_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int sval(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count_o == 0, "R1 count", sval(count_o), 0);
    chk(!evt_o && !irq_o, "R1 evt/irq", int'(evt_o) + int'(irq_o), 0);
    chk(status_o == 0 && zmode_o == 0, "R1 status/zmode", int'(status_o), 0);

    // R2/R3/R4 table of edge actions, control modes and dual-channel sums
    for (int v = 0; v < NVEC; v++) begin
      rise_act_i = {VEC[v].ra1, VEC[v].ra0};
      fall_act_i = {VEC[v].fa1, VEC[v].fa0};
      hi_mode_i  = {VEC[v].hm1, VEC[v].hm0};
      lo_mode_i  = {VEC[v].lm1, VEC[v].lm0};
      ctrl_i     = VEC[v].ctl;
      strobe_clr();
      pulses(VEC[v].msk, 3, 4);
      chk(sval(count_o) == int'(VEC[v].exp), $sformatf("R2/R3/R4 row %0d", v),
          sval(count_o), int'(VEC[v].exp));
    end
    ctrl_i = '0; hi_mode_i = '0; lo_mode_i = '0; fall_act_i = '0;
    rise_act_i = 4'b0001;

    // R6 hold freezes the count
    strobe_clr();
    cnt_hold_i = 1'b1;
    pulses(2'b01, 3, 4);
    chk(count_o == 0, "R6 hold", sval(count_o), 0);
    cnt_hold_i = 1'b0;
    pulses(2'b01, 2, 4);
    chk(count_o == 2, "R6 resume", sval(count_o), 2);

    // R7 clear wins over hold
    cnt_hold_i = 1'b1;
    strobe_clr();
    chk(count_o == 0, "R7 clear under hold", sval(count_o), 0);
    cnt_hold_i = 1'b0;

    // R5 filter boundary
    flt_en_i = 1'b1; flt_thr_i = 10'd5;
    pulses(2'b01, 2, 4);
    chk(count_o == 0, "R5 short pulse dropped", sval(count_o), 0);
    pulses(2'b01, 1, 5);
    chk(count_o == 1, "R5 threshold pulse counted", sval(count_o), 1);
    flt_en_i = 1'b0;
    pulses(2'b01, 1, 1);
    chk(count_o == 2, "R5 filter off", sval(count_o), 2);

    // R8/R9/R10/R11/R12 high limit
    strobe_clr(); strobe_evt_clr();
    hlim_i = 16'd3; cmp_en_i = 5'b00010; evt_ie_i = 1'b1;
    pulses(2'b01, 3, 4);
    chk(count_o == 0, "R8 high limit wrap", sval(count_o), 0);
    chk(evt_o && irq_o, "R9/R10 event raised", int'(evt_o) + int'(irq_o), 2);
    chk(status_o == 5'b00010, "R11 high bit", int'(status_o), 2);
    chk(zmode_o == 2'd3, "R12 positive", int'(zmode_o), 3);
    evt_ie_i = 1'b0;
    @(negedge clk);
    chk(!irq_o && evt_o, "R10 gated", int'(irq_o), 0);
    repeat (20) @(negedge clk);
    chk(evt_o, "R9 sticky", int'(evt_o), 1);
    strobe_evt_clr();
    chk(!evt_o, "R9 cleared", int'(evt_o), 0);

    // R11/R12 threshold 0
    cmp_en_i = 5'b01000; thr0_i = 16'd2;
    strobe_clr();
    pulses(2'b01, 2, 4);
    chk(count_o == 2 && evt_o, "R9 thr0 event, no wrap", sval(count_o), 2);
    chk(status_o == 5'b01000, "R11 thr0 bit", int'(status_o), 8);
    chk(zmode_o == 2'd3, "R12 thr0 positive", int'(zmode_o), 3);

    // R11/R12 threshold 1 negative
    cmp_en_i = 5'b10000; thr1_i = 16'hFFFF; rise_act_i = 4'b0010;
    strobe_clr(); strobe_evt_clr();
    pulses(2'b01, 1, 4);
    chk(sval(count_o) == -1, "R2 decrement", sval(count_o), -1);
    chk(status_o == 5'b10000, "R11 thr1 bit", int'(status_o), 16);
    chk(zmode_o == 2'd2, "R12 negative", int'(zmode_o), 2);

    // R12 zero reached from negative, then from positive
    cmp_en_i = 5'b00001; rise_act_i = 4'b0001;
    pulses(2'b01, 1, 4);
    chk(status_o == 5'b00001, "R11 zero bit", int'(status_o), 1);
    chk(zmode_o == 2'd1, "R12 zero from negative", int'(zmode_o), 1);
    pulses(2'b01, 1, 4);
    rise_act_i = 4'b0010;
    pulses(2'b01, 1, 4);
    chk(zmode_o == 2'd0, "R12 zero from positive", int'(zmode_o), 0);

    // R8/R11 low limit
    cmp_en_i = 5'b00100; llim_i = 16'hFFFE;
    strobe_clr(); strobe_evt_clr();
    pulses(2'b01, 2, 4);
    chk(count_o == 0, "R8 low limit wrap", sval(count_o), 0);
    chk(status_o == 5'b00100, "R11 low bit", int'(status_o), 4);
    chk(zmode_o == 2'd2, "R12 low negative", int'(zmode_o), 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule